// File: doc/BRIEF.md
# CPU Interrupt Wake-Up Dispatcher

When an interruption of some class becomes pending, this block decides which of a set of CPUs is told about it. A notification strobe arrives with a class vector covering service, I/O and machine-check interruptions. The block then does two things. Every CPU gets a sticky hard-interrupt request flag, so that it checks the pending work later. A subset of CPUs also gets a one-cycle kick, which wakes or nudges that CPU.

Which CPUs are kicked depends on the state each CPU reports:

- A 2-bit run state.
- A halted flag.
- Three program-status enable bits: external, I/O and machine check.

A running CPU in an active run state is always kicked. A halted CPU is kicked only when its status word enables the class being signalled. A CPU in an inactive run state is never kicked.

Top module: `cpu_wake_dispatch`

## Requirements
- R1: After reset, every `hard_req` bit and every `kick` bit is 0.
- R2: A cycle with `notify_vld` high sets every `hard_req` bit from the next cycle on, for every CPU, whatever its run state, halted flag or enables.
- R3: `req_ack[i]` high in a cycle without a notification clears `hard_req[i]` from the next cycle on and leaves the other bits unchanged. When the acknowledge and a notification come in the same cycle, the flag stays set.
- R4: Run state is 2 bits per CPU: 0 = stopped, 1 = check-stop, 2 = operating, 3 = load. A CPU in state 0 or 1 is never kicked.
- R5: A CPU in state 2 or 3 that is not halted is kicked. The kick is high for exactly the one cycle after the notification cycle.
- R6: The class vector uses bit 0 for service, bit 1 for I/O and bit 2 for machine check. A halted active CPU is kicked for a service-class notification only if its `en_ext` bit is set.
- R7: A halted active CPU is kicked for an I/O notification (bit 0 clear) only if its `en_io` bit is set.
- R8: A halted active CPU is kicked for a machine-check-only notification only if its `en_mchk` bit is set.
- R9: When several class bits are set, only one enable is tested. Service is chosen first, then I/O, then machine check. The enables of the classes not chosen have no effect.
- R10: A halted active CPU is kicked when the class vector is all zero.
- R11: No kick is produced in a cycle that does not follow a notification cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| notify_vld | input | 1 | Notification strobe, one cycle per notification |
| notify_cls | input | 3 | Class vector: bit 0 service, bit 1 I/O, bit 2 machine check |
| run_state | input | 2*NCPU | Run state of each CPU, 2 bits per CPU, CPU i at [2i+1:2i] |
| halted | input | NCPU | CPU is halted, waiting for an interruption |
| en_ext | input | NCPU | External-interrupt enable from each CPU's status word |
| en_io | input | NCPU | I/O enable from each CPU's status word |
| en_mchk | input | NCPU | Machine-check enable from each CPU's status word |
| req_ack | input | NCPU | Per-CPU clear of the hard-interrupt request flag |
| hard_req | output | NCPU | Sticky hard-interrupt request flag per CPU |
| kick | output | NCPU | One-cycle wake pulse per CPU |

## Verification
The hardest situation to reach is the priority case. A halted CPU sees several class bits at once, and its enables are set so that only the enable of a lower-priority class would grant the kick. A table of single-notification vectors creates this case for both class pairs. In each vector one enable pattern must block the kick and the mirror pattern must allow it. The stopped CPUs beside the one under test stay enabled for everything and must stay silent. A further directed step drives all CPUs at once with different states, and another places an acknowledge in the same cycle as a notification.

// File: rtl/cpu_wake_dispatch.sv
module cpu_wake_dispatch #(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              notify_vld,
  input  logic [2:0]        notify_cls,
  input  logic [2*NCPU-1:0] run_state,
  input  logic [NCPU-1:0]   halted,
  input  logic [NCPU-1:0]   en_ext,
  input  logic [NCPU-1:0]   en_io,
  input  logic [NCPU-1:0]   en_mchk,
  input  logic [NCPU-1:0]   req_ack,
  output logic [NCPU-1:0]   hard_req,
  output logic [NCPU-1:0]   kick
);

  localparam int CLS_SVC = 0;
  localparam int CLS_IO  = 1;
  localparam int CLS_MCK = 2;

  logic [NCPU-1:0] active;
  logic [NCPU-1:0] gate;
  logic [NCPU-1:0] want;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    assign active[i] = run_state[2*i+1];
    assign gate[i]   = notify_cls[CLS_SVC] ? en_ext[i]  :
                       notify_cls[CLS_IO]  ? en_io[i]   :
                       notify_cls[CLS_MCK] ? en_mchk[i] : 1'b1;
    assign want[i]   = active[i] & (~halted[i] | gate[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hard_req <= '0;
      kick     <= '0;
    end else begin
      kick     <= notify_vld ? want : '0;
      hard_req <= notify_vld ? '1 : (hard_req & ~req_ack);
    end
  end

endmodule

module cpu_wake_dispatch_chk #(
  parameter int NCPU = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              notify_vld,
  input logic [2*NCPU-1:0] run_state,
  input logic [NCPU-1:0]   halted,
  input logic [NCPU-1:0]   req_ack,
  input logic [NCPU-1:0]   hard_req,
  input logic [NCPU-1:0]   kick
);

  a_r2_all_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
    notify_vld |=> (hard_req == {NCPU{1'b1}}));

  for (genvar i = 0; i < NCPU; i++) begin : g_chk
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!notify_vld && req_ack[i]) |=> !hard_req[i]);
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!notify_vld && !req_ack[i] && hard_req[i]) |=> hard_req[i]);
    a_r4_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (notify_vld && !run_state[2*i+1]) |=> !kick[i]);
    a_r5_running_kicked: assert property (@(posedge clk) disable iff (!rst_n)
      (notify_vld && run_state[2*i+1] && !halted[i]) |=> kick[i]);
    a_r11_kick_needs_notify: assert property (@(posedge clk) disable iff (!rst_n)
      (!notify_vld) |=> !kick[i]);
    a_r2_kick_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
      kick[i] |-> hard_req[i]);
  end

endmodule

bind cpu_wake_dispatch cpu_wake_dispatch_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .notify_vld(notify_vld), .run_state(run_state),
  .halted(halted), .req_ack(req_ack), .hard_req(hard_req), .kick(kick)
);

// File: tb/tb_cpu_wake_dispatch.sv
module tb_cpu_wake_dispatch;
  localparam int NCPU = 4;
  localparam int NV   = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              notify_vld;
  logic [2:0]        notify_cls;
  logic [2*NCPU-1:0] run_state;
  logic [NCPU-1:0]   halted, en_ext, en_io, en_mchk, req_ack;
  logic [NCPU-1:0]   hard_req, kick;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cpu_wake_dispatch #(.NCPU(NCPU)) dut (
    .clk(clk), .rst_n(rst_n), .notify_vld(notify_vld), .notify_cls(notify_cls),
    .run_state(run_state), .halted(halted), .en_ext(en_ext), .en_io(en_io),
    .en_mchk(en_mchk), .req_ack(req_ack), .hard_req(hard_req), .kick(kick)
  );

  // Entry layout: {cls[2:0], state[1:0], halted, ext, io, mchk, expected kick}
  localparam logic [9:0] VEC [NV] = '{
    {3'b001, 2'd2, 1'b0, 3'b000, 1'b1},  // R5 running operating
    {3'b001, 2'd3, 1'b0, 3'b000, 1'b1},  // R5 running load
    {3'b001, 2'd0, 1'b0, 3'b111, 1'b0},  // R4 stopped
    {3'b001, 2'd1, 1'b1, 3'b111, 1'b0},  // R4 check-stop
    {3'b001, 2'd2, 1'b1, 3'b100, 1'b1},  // R6 service, ext on
    {3'b001, 2'd2, 1'b1, 3'b011, 1'b0},  // R6 service, ext off
    {3'b010, 2'd2, 1'b1, 3'b010, 1'b1},  // R7 io, io on
    {3'b010, 2'd3, 1'b1, 3'b101, 1'b0},  // R7 io, io off
    {3'b100, 2'd2, 1'b1, 3'b001, 1'b1},  // R8 mchk on
    {3'b100, 2'd2, 1'b1, 3'b110, 1'b0},  // R8 mchk off
    {3'b011, 2'd2, 1'b1, 3'b010, 1'b0},  // R9 service beats io
    {3'b011, 2'd2, 1'b1, 3'b100, 1'b1},  // R9 service chosen
    {3'b110, 2'd2, 1'b1, 3'b001, 1'b0},  // R9 io beats mchk
    {3'b110, 2'd2, 1'b1, 3'b010, 1'b1},  // R9 io chosen
    {3'b000, 2'd2, 1'b1, 3'b000, 1'b1},  // R10 empty class
    {3'b000, 2'd0, 1'b1, 3'b111, 1'b0}   // R4 empty class, stopped
  };

  function automatic string vec_req(int k);
    case (k)
      0, 1:           return "R5";
      2, 3, 15:       return "R4";
      4, 5:           return "R6";
      6, 7:           return "R7";
      8, 9:           return "R8";
      10, 11, 12, 13: return "R9";
      default:        return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [NCPU-1:0] act, logic [NCPU-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; notify_vld = 1'b0; notify_cls = '0; run_state = '0;
    halted = '0; en_ext = '0; en_io = '0; en_mchk = '0; req_ack = '0;
    repeat (3) tick();
    check("R1", hard_req, '0);
    check("R1", kick, '0);
    rst_n = 1'b1;
    tick();

    // R11: running CPUs, no strobe, no kick
    run_state = {2'd2, 2'd3, 2'd2, 2'd3};
    repeat (3) begin
      tick();
      check("R11", kick, '0);
    end

    // Table: CPU 0 under test, CPUs 1..3 stopped with all enables set
    for (int k = 0; k < NV; k++) begin
      notify_cls = VEC[k][9:7];
      run_state  = {2'd0, 2'd0, 2'd0, VEC[k][6:5]};
      halted     = {3'b111, VEC[k][4]};
      en_ext     = {3'b111, VEC[k][3]};
      en_io      = {3'b111, VEC[k][2]};
      en_mchk    = {3'b111, VEC[k][1]};
      notify_vld = 1'b1;
      tick();
      notify_vld = 1'b0;
      check(vec_req(k), kick, {3'b000, VEC[k][0]});
      check("R2", hard_req, '1);
      tick();
      check("R5", kick, '0);
    end

    // All CPUs at once, I/O class
    notify_cls = 3'b010;
    run_state  = {2'd1, 2'd2, 2'd3, 2'd2};
    halted     = 4'b0110;
    en_io      = 4'b1010;
    en_ext     = 4'b0101;
    en_mchk    = 4'b0101;
    notify_vld = 1'b1;
    tick();
    notify_vld = 1'b0;
    check("R7", kick, 4'b0011);

    // R3: ack clears one flag only
    req_ack = 4'b0100;
    tick();
    req_ack = '0;
    check("R3", hard_req, 4'b1011);
    tick();
    check("R3", hard_req, 4'b1011);

    // R3: ack together with notification keeps the flag
    req_ack = 4'b1111;
    notify_vld = 1'b1;
    tick();
    req_ack = '0;
    notify_vld = 1'b0;
    check("R3", hard_req, 4'b1111);

    // R1: reset clears flags
    rst_n = 1'b0;
    tick();
    check("R1", hard_req, '0);
    check("R1", kick, '0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule